// File: doc/BRIEF.md
# Prioritized CPU Interrupt Arbiter

This block decides which pending asynchronous interrupt a processor core takes next. It keeps one pending bit for each of sixteen interrupt sources. Any source can be raised through a set input and dropped through a clear input. When the core asserts an evaluation strobe, the block looks at the pending bits and at the core's gating state: the external-enable bit, the hypervisor and problem-state bits, a power-save resume flag, two partition enables for the hypervisor timer and virtualization sources, an external-block bit, an external-to-supervisor bit and a hypervisor-present bit. From these it picks at most one source.

The winner appears one clock after the strobe as a one-hot grant with a single-cycle valid pulse. Edge-type sources lose their pending bit at the same clock edge. Level-type sources keep theirs until the requester clears them. A summary output tells the core whether anything is still pending, so it can drop its interrupt request. If an evaluation happens during a power-save resume and nothing can be delivered, a sticky error flag is raised.

Top module: `irq_arbiter`

## Requirements
- R1: Sources are indexed by priority, with index 0 the highest: 0 system reset, 1 machine check, 2 debug, 3 hypervisor timer, 4 hypervisor virtualization, 5 external, 6 critical external, 7 watchdog, 8 critical doorbell, 9 fixed-interval timer, 10 programmable timer, 11 decrementer, 12 doorbell, 13 hypervisor doorbell, 14 performance monitor, 15 thermal. The grant goes to the lowest-indexed source that is both pending and eligible.
- R2: Sources 0, 1 and 2 are eligible whatever the gating inputs are. Each one's pending bit clears when it is granted.
- R3: Asynchronous delivery is enabled when ee_i or resume_i is 1. Sources 7 to 15 are eligible only while it is enabled. Each of them clears on grant, except source 11.
- R4: Source 3 is eligible when hdec_en_i is 1 and either asynchronous delivery is enabled or hv_i is 0. It clears on grant.
- R5: Source 4 uses the same gating as source 3 but with hvirt_en_i. Its pending bit stays set after a grant.
- R6: Source 5 is eligible in two cases: asynchronous delivery is enabled and the condition (ext_hv_block_i=1 and hv_i=1 and pr_i=0) is false; or hv_present_i=1, hv_i=0 and ext_to_sup_i=0. Its pending bit stays set after a grant.
- R7: Source 6 is eligible whatever the gating inputs are. Its pending bit stays set after a grant.
- R8: Source 11 clears on grant only when dec_clr_grant_i is 1.
- R9: The grant from a strobe shows on the outputs in the next cycle: grant_vld_o is high for exactly that one cycle and grant_o is one-hot. Without a strobe, grant_vld_o=0 and grant_o=0. A strobe that finds nothing eligible also gives grant_vld_o=0.
- R10: A pending bit sets one cycle after its set_i bit and clears one cycle after its clr_i bit. A set wins over an external clear or a grant clear in the same cycle.
- R11: pend_o shows the pending bits, and any_pend_o is 1 exactly when at least one of them is set.
- R12: resume_err_o becomes 1 one cycle after a strobe in which resume_i=1 and no source is granted. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluation strobe |
| set_i | input | 16 | Per-source request set |
| clr_i | input | 16 | Per-source external clear |
| ee_i | input | 1 | External-enable bit |
| hv_i | input | 1 | Hypervisor state bit |
| pr_i | input | 1 | Problem-state bit |
| resume_i | input | 1 | Power-save resume flag |
| hdec_en_i | input | 1 | Partition enable for the hypervisor timer |
| hvirt_en_i | input | 1 | Partition enable for hypervisor virtualization |
| ext_hv_block_i | input | 1 | Blocks external delivery to the hypervisor |
| ext_to_sup_i | input | 1 | Routes external interrupts to the supervisor |
| hv_present_i | input | 1 | Hypervisor mode is implemented |
| dec_clr_grant_i | input | 1 | Decrementer clears on grant |
| grant_o | output | 16 | One-hot granted source |
| grant_vld_o | output | 1 | Grant valid pulse |
| pend_o | output | 16 | Pending bits |
| any_pend_o | output | 1 | At least one bit pending |
| resume_err_o | output | 1 | Sticky undelivered-resume error |

## Verification
A corrupted pending bit shows on pend_o and any_pend_o one cycle after the event that corrupted it. At the next strobe it also shows as a grant to the wrong source, or as no grant at all. A wrong eligibility term or a wrong priority order only becomes visible when a strobe happens. It then shows in the cycle right after that strobe, either in grant_o or in the pending bit that should have cleared. The sweep therefore strobes every source under every combination of gating inputs, and a faulty term shows up within the first four cycles of the case that exposes it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NSRC  = 16;
  localparam int unsigned IDX_W = $clog2(NSRC);

  // Priority positions: lower index wins.
  localparam int unsigned IX_SRESET = 0;
  localparam int unsigned IX_MCHK   = 1;
  localparam int unsigned IX_DEBUG  = 2;
  localparam int unsigned IX_HTMR   = 3;
  localparam int unsigned IX_HVIRT  = 4;
  localparam int unsigned IX_EXT    = 5;
  localparam int unsigned IX_CEXT   = 6;
  localparam int unsigned IX_WDOG   = 7;
  localparam int unsigned IX_CDBELL = 8;
  localparam int unsigned IX_FIT    = 9;
  localparam int unsigned IX_PIT    = 10;
  localparam int unsigned IX_DEC    = 11;
  localparam int unsigned IX_DBELL  = 12;
  localparam int unsigned IX_HDBELL = 13;
  localparam int unsigned IX_PERF   = 14;
  localparam int unsigned IX_THERM  = 15;

  // Sources the arbiter never clears on its own.
  localparam logic [NSRC-1:0] LEVEL_MASK =
    (NSRC'(1) << IX_HVIRT) | (NSRC'(1) << IX_EXT) | (NSRC'(1) << IX_CEXT);

  // Sources gated only by asynchronous delivery.
  localparam logic [NSRC-1:0] ASYNC_MASK =
    {NSRC{1'b1}} << IX_WDOG;

  typedef struct packed {
    logic ee;
    logic hv;
    logic pr;
    logic resume;
    logic htmr_en;
    logic hvirt_en;
    logic ext_blk;
    logic ext_sup;
    logic hv_present;
  } gate_ctl_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  gate_ctl_t       ctl,
  output logic [NSRC-1:0] elig
);
  logic async_en;
  logic hv_route_ok;
  logic ext_async_ok;
  logic ext_part_ok;
  logic [NSRC-1:0] allow;

  always_comb begin
    async_en     = ctl.ee | ctl.resume;
    hv_route_ok  = async_en | ~ctl.hv;
    ext_async_ok = async_en & ~(ctl.ext_blk & ctl.hv & ~ctl.pr);
    ext_part_ok  = ctl.hv_present & ~ctl.hv & ~ctl.ext_sup;

    allow            = ASYNC_MASK & {NSRC{async_en}};
    allow[IX_SRESET] = 1'b1;
    allow[IX_MCHK]   = 1'b1;
    allow[IX_DEBUG]  = 1'b1;
    allow[IX_HTMR]   = ctl.htmr_en & hv_route_ok;
    allow[IX_HVIRT]  = ctl.hvirt_en & hv_route_ok;
    allow[IX_EXT]    = ext_async_ok | ext_part_ok;
    allow[IX_CEXT]   = 1'b1;

    elig = pend & allow;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] take,
  output logic         hit
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_pri
      if (gi == 0) begin : g_top
        assign take[gi] = req[gi];
      end else begin : g_rest
        assign take[gi] = req[gi] & ~(|req[gi-1:0]);
      end
    end
  endgenerate

  assign hit = |req;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  input  logic [N-1:0] gclr_v,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         upd_en;

  always_comb begin
    pend_d = (pend_q & ~clr_v & ~gclr_v) | set_v;
    upd_en = |{set_v, clr_v, gclr_v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_i,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            ee_i,
  input  logic            hv_i,
  input  logic            pr_i,
  input  logic            resume_i,
  input  logic            hdec_en_i,
  input  logic            hvirt_en_i,
  input  logic            ext_hv_block_i,
  input  logic            ext_to_sup_i,
  input  logic            hv_present_i,
  input  logic            dec_clr_grant_i,
  output logic [NSRC-1:0] grant_o,
  output logic            grant_vld_o,
  output logic [NSRC-1:0] pend_o,
  output logic            any_pend_o,
  output logic            resume_err_o
);
  logic            rst_n_s;
  gate_ctl_t       ctl;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] take;
  logic            hit;
  logic [NSRC-1:0] clr_on_grant;
  logic [NSRC-1:0] gclr;

  logic [NSRC-1:0] grant_d, grant_q;
  logic            vld_d, vld_q;
  logic            err_d, err_q;
  logic            out_en;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    ctl.ee         = ee_i;
    ctl.hv         = hv_i;
    ctl.pr         = pr_i;
    ctl.resume     = resume_i;
    ctl.htmr_en    = hdec_en_i;
    ctl.hvirt_en   = hvirt_en_i;
    ctl.ext_blk    = ext_hv_block_i;
    ctl.ext_sup    = ext_to_sup_i;
    ctl.hv_present = hv_present_i;
  end

  irq_gate u_gate (
    .pend (pend),
    .ctl  (ctl),
    .elig (elig)
  );

  irq_pick #(.N(NSRC)) u_pick (
    .req  (elig),
    .take (take),
    .hit  (hit)
  );

  // Next-state for grant, pulse and sticky error.
  always_comb begin
    clr_on_grant         = ~LEVEL_MASK;
    clr_on_grant[IX_DEC] = dec_clr_grant_i;
    grant_d              = eval_i ? take : '0;
    vld_d                = eval_i & hit;
    err_d                = err_q | (eval_i & resume_i & ~hit);
    gclr                 = grant_d & clr_on_grant;
    out_en               = eval_i | vld_q;
  end

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_v  (set_i),
    .clr_v  (clr_i),
    .gclr_v (gclr),
    .pend   (pend)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      grant_q <= '0;
      vld_q   <= 1'b0;
    end else if (out_en) begin
      grant_q <= grant_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    err_q <= 1'b0;
    else if (eval_i) err_q <= err_d;
  end

  assign grant_o      = grant_q;
  assign grant_vld_o  = vld_q;
  assign pend_o       = pend;
  assign any_pend_o   = |pend;
  assign resume_err_o = err_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            eval_i,
  input logic [NSRC-1:0] set_i,
  input logic [NSRC-1:0] clr_i,
  input logic            ee_i,
  input logic            resume_i,
  input logic [NSRC-1:0] pend_o,
  input logic [NSRC-1:0] grant_o,
  input logic            grant_vld_o,
  input logic            resume_err_o
);
  // R9: grant is one-hot and silent without a valid pulse
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_vld_o || grant_o == '0));

  // R9: a valid pulse needs a strobe in the previous cycle
  p_vld_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> $past(eval_i));

  // R1: only a source that was pending may be granted
  p_gnt_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ((grant_o & ~$past(pend_o)) == '0));

  // R1: top-priority source always wins when pending at a strobe
  p_top_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eval_i) && $past(pend_o[IX_SRESET])) |-> (grant_vld_o && grant_o[IX_SRESET]));

  // R2: system reset clears on grant unless re-set
  p_sreset_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && grant_o[IX_SRESET] && !$past(set_i[IX_SRESET])) |-> !pend_o[IX_SRESET]);

  // R5: virtualization source stays pending after grant
  p_hvirt_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && grant_o[IX_HVIRT] && !$past(clr_i[IX_HVIRT])) |-> pend_o[IX_HVIRT]);

  // R3: async-only sources are not granted while delivery is disabled
  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eval_i) && !$past(ee_i) && !$past(resume_i)) |-> (grant_o[NSRC-1:IX_WDOG] == '0));

  // R12: error flag is sticky
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resume_err_o |=> resume_err_o);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .eval_i       (eval_i),
  .set_i        (set_i),
  .clr_i        (clr_i),
  .ee_i         (ee_i),
  .resume_i     (resume_i),
  .pend_o       (pend_o),
  .grant_o      (grant_o),
  .grant_vld_o  (grant_vld_o),
  .resume_err_o (resume_err_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  logic        clk;
  logic        rst_n;
  logic        eval_i;
  logic [15:0] set_i, clr_i;
  logic ee, hv, pr, res, hde, hve, blk, sup, hvm, decc;
  logic [15:0] grant_o, pend_o;
  logic        grant_vld_o, any_pend_o, resume_err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit exp_err = 0;
  bit done = 0;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .set_i(set_i), .clr_i(clr_i),
    .ee_i(ee), .hv_i(hv), .pr_i(pr), .resume_i(res), .hdec_en_i(hde),
    .hvirt_en_i(hve), .ext_hv_block_i(blk), .ext_to_sup_i(sup),
    .hv_present_i(hvm), .dec_clr_grant_i(decc),
    .grant_o(grant_o), .grant_vld_o(grant_vld_o), .pend_o(pend_o),
    .any_pend_o(any_pend_o), .resume_err_o(resume_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit elig_f(int s);
    bit a;
    a = ee | res;
    case (s)
      0, 1, 2, 6: return 1'b1;
      3: return hde && (a || !hv);
      4: return hve && (a || !hv);
      5: return (a && !(blk && hv && !pr)) || (hvm && !hv && !sup);
      default: return a;
    endcase
  endfunction

  function automatic bit clears_f(int s);
    if (s == 4 || s == 5 || s == 6) return 1'b0;
    if (s == 11) return decc;
    return 1'b1;
  endfunction

  function automatic string req_of(int s);
    case (s)
      0, 1, 2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      11: return "R8";
      default: return "R3";
    endcase
  endfunction

  // Clear all, then load pattern p; ends on a negedge with pend loaded.
  task automatic load(input logic [15:0] p);
    clr_i = '1; set_i = '0;
    @(negedge clk);
    clr_i = '0; set_i = p;
    @(negedge clk);
    set_i = '0;
  endtask

  // Strobe once; returns on the negedge where the grant is visible.
  task automatic strobe();
    eval_i = 1'b1;
    @(negedge clk);
    eval_i = 1'b0;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf;
    rst_n = 1'b0; eval_i = 1'b0; set_i = '0; clr_i = '0;
    {ee, hv, pr, res, hde, hve, blk, sup, hvm, decc} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    chk(pend_o == 0 && any_pend_o == 0, "R11 reset pend", {16'h0, pend_o}, 0);
    chk(grant_vld_o == 0 && grant_o == 0, "R9 reset grant", {15'h0, grant_vld_o, grant_o}, 0);
    chk(resume_err_o == 0, "R12 reset err", resume_err_o, 0);

    // R10 set beats external clear, then external clear alone
    set_i = 16'h0020; clr_i = 16'h0020;
    @(negedge clk);
    set_i = '0; clr_i = '0;
    chk(pend_o == 16'h0020 && any_pend_o, "R10 set over clear", pend_o, 16'h0020);
    clr_i = 16'h0020;
    @(negedge clk);
    clr_i = '0;
    chk(pend_o == 0 && !any_pend_o, "R10 external clear", pend_o, 0);

    // R10 set beats grant clear
    load(16'h0001);
    set_i = 16'h0001;
    strobe();
    set_i = '0;
    chk(grant_vld_o && grant_o == 16'h0001, "R10 grant with set", grant_o, 16'h0001);
    chk(pend_o == 16'h0001, "R10 set over grant clear", pend_o, 16'h0001);

    // R9 no strobe, no grant; pulse is one cycle wide
    ee = 1'b1;
    load(16'h0100);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!grant_vld_o && grant_o == 0, "R9 no strobe", grant_o, 0);
    end
    strobe();
    chk(grant_vld_o && grant_o == 16'h0100, "R9 grant", grant_o, 16'h0100);
    @(negedge clk);
    chk(!grant_vld_o && grant_o == 0, "R9 pulse width", {15'h0, grant_vld_o, grant_o}, 0);
    ee = 1'b0;

    // R9 strobe with nothing eligible
    load(16'h8000);
    strobe();
    chk(!grant_vld_o, "R9 empty strobe", grant_vld_o, 0);
    chk(pend_o == 16'h8000, "R3 masked stays pending", pend_o, 16'h8000);

    // Sweep: every source under every gating combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 1024; c++) begin
        logic [9:0] cv;
        bit e;
        logic [15:0] eg, ep;
        cv = c[9:0];
        {ee, hv, pr, res, hde, hve, blk, sup, hvm, decc} = cv;
        load(16'(1) << s);
        chk(pend_o == (16'(1) << s) && any_pend_o, "R11 load", pend_o, 16'(1) << s);
        strobe();
        e  = elig_f(s);
        eg = e ? (16'(1) << s) : 16'h0;
        ep = (e && clears_f(s)) ? 16'h0 : (16'(1) << s);
        if (res && !e) exp_err = 1'b1;
        chk(grant_vld_o == e && grant_o == eg, req_of(s), {cv, 5'h0, grant_vld_o, grant_o}, {cv, 5'h0, e, eg});
        chk(pend_o == ep, req_of(s), {cv, 6'h0, pend_o}, {cv, 6'h0, ep});
        chk(resume_err_o == exp_err, "R12 sticky", resume_err_o, exp_err);
      end
    end

    // Priority among many pending sources
    lf = 16'hACE1;
    for (int it = 0; it < 2000; it++) begin
      logic [15:0] eg, ep;
      int w;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      {ee, hv, pr, res, hde, hve, blk, sup, hvm, decc} = lf[9:0] ^ lf[15:6];
      load(lf);
      strobe();
      w = -1;
      for (int i = 15; i >= 0; i--) if (lf[i] && elig_f(i)) w = i;
      eg = (w >= 0) ? (16'(1) << w) : 16'h0;
      ep = lf;
      if (w >= 0 && clears_f(w)) ep[w] = 1'b0;
      if (res && w < 0) exp_err = 1'b1;
      chk(grant_vld_o == (w >= 0) && grant_o == eg, "R1 priority", grant_o, eg);
      chk(pend_o == ep && any_pend_o == (ep != 0), "R11 after grant", pend_o, ep);
      chk(resume_err_o == exp_err, "R12 sticky", resume_err_o, exp_err);
    end

    // R12 dedicated: fresh reset, empty resume strobe, then stays set
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(resume_err_o == 0, "R12 cleared by reset", resume_err_o, 0);
    {ee, hv, pr, res, hde, hve, blk, sup, hvm, decc} = '0;
    strobe();
    chk(resume_err_o == 0, "R12 no resume no error", resume_err_o, 0);
    res = 1'b1;
    strobe();
    chk(resume_err_o == 1, "R12 raised", resume_err_o, 1);
    res = 1'b0;
    load(16'h0001);
    strobe();
    chk(resume_err_o == 1, "R12 held", resume_err_o, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule